// File: doc/BRIEF.md
# Eight-Digit Display Decoder with Leading and Trailing Zero Suppression

This block drives an eight-digit seven-segment display from a fixed-point BCD number. A load strobe registers the number. Each digit is then decoded to an active-low segment vector. A blank flag marks the digits that must stay dark. The decimal point sits at a fixed position set by a parameter, and the block divides the digits into an integer field and a fraction field there.

Two zero-suppression chains run in opposite directions. In the integer field, a zero is blanked only when every digit above it up to the most significant end is also zero. In the fraction field, a zero is blanked only when every digit below it down to the least significant end is also zero. The two digits next to the point are always shown. A value such as 0060.0300 therefore reads as 60.03, and an all-zero value reads as 0.0.

Digit `i` occupies `bcd_in[4*i+3:4*i]`, and digit `DIGITS-1` is the most significant. Digits `0` to `DIGITS-INT_DIGITS-1` form the fraction, and the rest form the integer part. `INT_DIGITS` must be between 1 and `DIGITS-1`.

Top module: `zero_blank_display`

## Requirements
- R1: On a rising `clk` edge with `load` high, `bcd_in` is captured, and the outputs show the captured value right after that edge. When `load` is low, changes on `bcd_in` have no effect on the outputs.
- R2: While `rst_n` is low, the stored number is all zeros, so `blank` is 8'b1110_0111 and only digits 4 and 3 show a zero (default parameters).
- R3: A shown digit drives `seg_n[7*i+6:7*i]` = ~{g,f,e,d,c,b,a}, with the segment pattern in hex form: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71 (active-high gfedcba).
- R4: A blanked digit has `blank[i]`=1, and all seven of its `seg_n` bits are high.
- R5: An integer digit above the least significant integer digit is blanked exactly when it and every integer digit above it are zero.
- R6: The least significant integer digit (digit 4) is never blanked, so it shows 0 when the whole integer part is zero.
- R7: A fraction digit below the most significant fraction digit is blanked exactly when it and every fraction digit below it are zero.
- R8: The most significant fraction digit (digit 3) is never blanked.
- R9: Zeros that lie between nonzero digits within a field are shown. For example, 0x00600300 shows "60.03" and 0x10010100 shows "1001.01".
- R10: A nonzero digit, including the values A to F, is never blanked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the stored number |
| load | input | 1 | Capture `bcd_in` on the next rising edge |
| bcd_in | input | 4*DIGITS | Packed digits, most significant digit in the top nibble |
| seg_n | output | 7*DIGITS | Active-low segments {g..a}, seven bits per digit |
| blank | output | DIGITS | One per digit; 1 means the digit is suppressed |

## Verification
The bench goes after the digits next to the point with all-zero fields. A design that blanks them would show an empty display instead of 0.0. It also loads values with zeros embedded between nonzero digits, such as 1001.01. A chain that tests only the digit's own value would blank those inner zeros, and a chain running the wrong way in the fraction would blank leading fraction zeros such as in .0300. Finally, it loads hex letters at the chain ends and changes the input with `load` low. These cases expose a zero test that misreads A to F, and a register that does not hold its value.

// File: rtl/zero_blank_display.sv
module zero_blank_display #(
  parameter int DIGITS     = 8,
  parameter int INT_DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [4*DIGITS-1:0]   bcd_in,
  output logic [7*DIGITS-1:0]   seg_n,
  output logic [DIGITS-1:0]     blank
);
  localparam int FRAC = DIGITS - INT_DIGITS;

  logic [DIGITS-1:0][3:0] num_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    num_q <= '0;
    else if (load) num_q <= bcd_in;

  function automatic logic [6:0] hex7(input logic [3:0] v);
    case (v)
      4'h0: hex7 = 7'h3F;  4'h1: hex7 = 7'h06;
      4'h2: hex7 = 7'h5B;  4'h3: hex7 = 7'h4F;
      4'h4: hex7 = 7'h66;  4'h5: hex7 = 7'h6D;
      4'h6: hex7 = 7'h7D;  4'h7: hex7 = 7'h07;
      4'h8: hex7 = 7'h7F;  4'h9: hex7 = 7'h6F;
      4'hA: hex7 = 7'h77;  4'hB: hex7 = 7'h7C;
      4'hC: hex7 = 7'h39;  4'hD: hex7 = 7'h5E;
      4'hE: hex7 = 7'h79;  default: hex7 = 7'h71;
    endcase
  endfunction

  always_comb begin
    logic run;
    blank = '0;
    run = 1'b1;
    for (int i = DIGITS - 1; i > FRAC; i--) begin
      run = run & (num_q[i] == 4'h0);
      blank[i] = run;
    end
    run = 1'b1;
    for (int i = 0; i < FRAC - 1; i++) begin
      run = run & (num_q[i] == 4'h0);
      blank[i] = run;
    end
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign seg_n[7*i +: 7] = blank[i] ? 7'h7F : ~hex7(num_q[i]);

    AST_BLANK_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      blank[i] |-> num_q[i] == 4'h0); // R10
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      blank[i] |-> seg_n[7*i +: 7] == 7'h7F); // R4

    if (i > FRAC && i < DIGITS - 1) begin : g_int
      AST_INT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        blank[i] |-> blank[i+1]); // R5
    end
    if (i > 0 && i < FRAC - 1) begin : g_frac
      AST_FRAC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        blank[i] |-> blank[i-1]); // R7
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> num_q == $past(bcd_in)); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(num_q)); // R1
endmodule

// File: tb/zero_blank_display_bench.sv
module zero_blank_display_bench;
  localparam int N = 8;
  localparam int FR = 4;

  typedef struct {
    logic [N-1:0]   b;
    logic [7*N-1:0] s;
    string          tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [4*N-1:0] bcd_in = '0;
  logic [7*N-1:0] seg_n;
  logic [N-1:0]   blank;

  int checks = 0;
  int fails = 0;
  bit cap_seen = 1'b0;
  item_t sb[$];
  item_t last;

  always #5 clk = ~clk;

  zero_blank_display #(.DIGITS(N), .INT_DIGITS(N-FR)) u_zero_blank_display (
    .clk(clk), .rst_n(rst_n), .load(load), .bcd_in(bcd_in),
    .seg_n(seg_n), .blank(blank));

  function automatic logic [6:0] pat(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  function automatic item_t model(input logic [4*N-1:0] v, input string tag);
    item_t it;
    int top_nz;
    int low_nz;
    it.tag = tag;
    top_nz = FR;
    for (int d = FR; d < N; d++) if (v[4*d +: 4] != 0) top_nz = d;
    low_nz = FR - 1;
    for (int d = FR - 1; d >= 0; d--) if (v[4*d +: 4] != 0) low_nz = d;
    for (int d = 0; d < N; d++) begin
      it.b[d] = (d >= FR) ? (d > top_nz) : (d < low_nz);
      it.s[7*d +: 7] = it.b[d] ? 7'h7F : ~pat(v[4*d +: 4]);
    end
    return it;
  endfunction

  task automatic compare(input item_t e);
    checks++;
    if (blank !== e.b) begin
      fails++;
      $display("FAIL %s blank got %b exp %b", e.tag, blank, e.b);
    end
    checks++;
    if (seg_n !== e.s) begin
      fails++;
      $display("FAIL %s seg_n got %h exp %h", e.tag, seg_n, e.s);
    end
  endtask

  task automatic apply(input logic [4*N-1:0] v, input string tag);
    @(negedge clk);
    bcd_in = v;
    load = 1'b1;
    last = model(v, tag);
    sb.push_back(last);
    @(negedge clk);
    load = 1'b0;
  endtask

  always @(posedge clk) cap_seen <= load && rst_n;

  always @(negedge clk) begin
    if (cap_seen) begin
      if (sb.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R1 unexpected capture got %b exp none", blank);
      end else compare(sb.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got timeout exp finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    item_t r;
    repeat (3) @(negedge clk);
    r = model('0, "R2 reset");
    r.b = 8'b1110_0111;
    compare(r);
    rst_n = 1'b1;

    apply(32'h0060_0300, "R9 R5 R7 60.03");
    apply(32'h0000_0000, "R6 R8 all zero");
    apply(32'h1234_5678, "R3 R10 no zeros");
    apply(32'hFEDC_BA98, "R3 R10 hex letters");
    apply(32'h1001_0100, "R9 inner zeros");
    apply(32'h0000_0001, "R6 R8 R7 fraction end");
    apply(32'h9000_0000, "R6 R8 R7 integer top");
    apply(32'h000A_A000, "R5 R7 R10 letters at point");
    apply(32'h0500_0050, "R5 R7 R4");
    apply(32'h0009_0900, "R9 R8 inner fraction zero");

    @(negedge clk);
    bcd_in = 32'h7777_7777;
    @(negedge clk);
    @(negedge clk);
    last.tag = "R1 hold without load";
    compare(last);

    apply(32'h0000_0000, "R2 R4 back to zero");
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R1 pending got %0d exp 0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule